// File: doc/BRIEF.md
# Cascadable Serial Fault Snapshot Register

This block sits between a set of per-channel fault flags and a four-wire SPI slave port. Each channel has two flags: an over-temperature flag and an open-load flag. The whole block runs on a fast system clock. Chip select, serial clock and serial data-in are brought into that clock domain through synchronizer chains, and all edge decisions are made on the synchronized copies. The system clock must run at least four times faster than the serial clock.

When chip select is asserted (driven low), the current flags are frozen into a shift register. The register is then shifted out most significant bit first, in clock-idle-low mode with the second-edge phase: data-out changes on rising serial-clock edges, and data-in is captured on falling edges. Because data-in comes back out on data-out eight clocks later, several devices wired output-to-input act as one long register.

The control is a three-state machine:
- `ST_IDLE`: chip select is high and data-out is released.
- `ST_LEAD`: chip select is low and data-out is driven low until the first rising clock.
- `ST_SHIFT`: bits are moving.

Transitions:
- `ST_IDLE` to `ST_LEAD` on a chip-select fall. This transition also takes the snapshot.
- `ST_LEAD` to `ST_SHIFT` on a rising serial clock.
- `ST_LEAD` or `ST_SHIFT` back to `ST_IDLE` on a chip-select rise.

The block reset returns the machine to `ST_IDLE`. It does not clear the shift register contents.

Top module: `fault_chain_spi`

## Requirements
- R1: A synchronized falling edge of `cs_n` seen in `ST_IDLE` loads every flag in parallel. Flag changes after that edge do not affect the bits shifted out in that transfer.
- R2: Snapshot bit k holds `ot_flag[k]` for k = 0..NCH-1 and `ol_flag[k-NCH]` for k = NCH..2*NCH-1. The top bit is shifted out first and bit 0 last.
- R3: While `cs_n` is high (`ST_IDLE`), `so_oe` is 0 and `so` reads 0.
- R4: After the chip-select fall and before the first rising `sck`, `so_oe` is 1 and `so` is 0.
- R5: The n-th rising `sck` edge of a transfer (n = 1..8) places snapshot bit 8-n on `so`.
- R6: `si` is captured on each falling `sck` edge in `ST_SHIFT`. The bit captured at the n-th falling edge appears on `so` at rising edge n+8.
- R7: A chip-select rise releases `so` and returns to `ST_IDLE` at once, even in the middle of a byte. The next transfer starts from a fresh snapshot.
- R8: If `sck` is high when `cs_n` falls, `proto_err` is set to 1 and the load still takes place. A later chip-select fall with `sck` low clears `proto_err` to 0.
- R9: While `rst_n` is low, the machine is in `ST_IDLE`, `so_oe` is 0 and `proto_err` is 0.
- R10: `so` does not change on a falling `sck` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low block reset; does not clear the shift register |
| ot_flag | input | NCH | Over-temperature flag per channel |
| ol_flag | input | NCH | Open-load flag per channel |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in (from the upstream device in a chain) |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| proto_err | output | 1 | Set when chip select fell while `sck` was high |

## Verification
The hardest situation to reach is a chip-select fall that arrives while `sck` is already high. After such a fall, the first clock movement the block sees is a falling edge in `ST_LEAD`. If that edge is mistaken for a capture, it would destroy the top bit.

The stimulus raises `sck` before dropping `cs_n`, then lowers `sck` while still in the lead phase. It then runs a full byte and checks that the entire snapshot, top bit included, still arrives intact. It also checks that a following clean transfer clears the error flag.

The chain behaviour is exercised with a sixteen-clock burst over all 256 flag patterns. In that burst, the data fed in for the first byte must reappear on `so` during the second byte.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/fcs_sync.sv
// Multi-bit, multi-stage synchronizer with a per-bit reset value.
module fcs_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stage_q[i] <= RST_VAL;
            else if (i == 0)
                stage_q[i] <= d;
            else
                stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fcs_edge.sv
// Rise/fall detection on already synchronized levels.
module fcs_edge #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= RST_VAL;
        else
            prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/fcs_shifter.sv
// Snapshot/shift register. Deliberately has no reset: a block reset leaves its contents alone.
module fcs_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] par_in,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic         msb
);
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (load)
            data_q <= par_in;
        else if (shift_en)
            data_q <= {data_q[W-2:0], ser_in};
    end

    assign msb = data_q[W-1];
endmodule

// File: rtl/fault_chain_spi.sv
module fault_chain_spi
    import fcs_pkg::*;
#(
    parameter int NCH = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ot_flag,
    input  logic [NCH-1:0] ol_flag,
    input  logic           cs_n,
    input  logic           sck,
    input  logic           si,
    output logic           so,
    output logic           so_oe,
    output logic           proto_err
);
    localparam int W = 2 * NCH;

    // synchronized {cs_n, sck, si}
    logic [2:0] line_s;
    logic       cs_n_s, sck_s, si_s;
    logic [1:0] ed_rise, ed_fall;
    logic       sel_start, sel_end, sck_rise, sck_fall;

    fcs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q(line_s)
    );
    assign {cs_n_s, sck_s, si_s} = line_s;

    fcs_edge #(.W(2), .RST_VAL(2'b10)) edge_i (
        .clk(clk), .rst_n(rst_n), .lvl({cs_n_s, sck_s}),
        .rise(ed_rise), .fall(ed_fall)
    );
    assign sel_start = ed_fall[1];
    assign sel_end   = ed_rise[1];
    assign sck_rise  = ed_rise[0];
    assign sck_fall  = ed_fall[0];

    xfer_state_t state_q, state_d;
    logic        load, shift_en, sh_msb;
    logic        so_q, err_q;
    logic [W-1:0] snap;

    assign snap = {ol_flag, ot_flag};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sel_start) state_d = ST_LEAD;
            ST_LEAD:  if (sel_end) state_d = ST_IDLE;
                      else if (sck_rise) state_d = ST_SHIFT;
            ST_SHIFT: if (sel_end) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign load     = (state_q == ST_IDLE) && sel_start;
    assign shift_en = (state_q == ST_SHIFT) && sck_fall && !sel_end;

    fcs_shifter #(.W(W)) shift_i (
        .clk(clk), .load(load), .par_in(snap),
        .shift_en(shift_en), .ser_in(si_s), .msb(sh_msb)
    );

    // serial output and error flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_q  <= 1'b0;
            err_q <= 1'b0;
        end else if (load) begin
            so_q  <= 1'b0;
            err_q <= sck_s;
        end else if ((state_q != ST_IDLE) && sck_rise && !sel_end) begin
            so_q  <= sh_msb;
        end
    end

    // outputs
    always_comb begin
        so_oe     = (state_q != ST_IDLE);
        so        = so_oe ? so_q : 1'b0;
        proto_err = err_q;
    end

    assert_release_on_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_end |=> !so_oe);
    assert_lead_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_start |=> (so_oe && !so));
    assert_snapshot_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sh_msb == $past(snap[W-1])));
    assert_err_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (proto_err == $past(sck_s)));
    assert_hold_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_rise && !sel_start) |=> $stable(so_q));
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $stable(cs_n_s)) |-> !so);
endmodule

// File: tb/fault_chain_spi_tb_top.sv
module fault_chain_spi_tb_top;
    localparam int NCH = 4;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] ot_flag = '0, ol_flag = '0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic so, so_oe, proto_err;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fault_chain_spi #(.NCH(NCH), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .ot_flag(ot_flag), .ol_flag(ol_flag),
        .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe),
        .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_flags(input logic [7:0] v);
        ot_flag = v[3:0];
        ol_flag = v[7:4];
    endtask

    // one serial clock period: drive si, rise, sample, fall, check hold
    task automatic spi_bit(input logic b, output logic seen);
        @(negedge clk);
        sck = 1'b1;
        si = b;
        wait_cyc(H);
        seen = so;
        sck = 1'b0;
        wait_cyc(H);
        chk("R10 so held over falling sck", so, seen);
    endtask

    task automatic select;
        @(negedge clk);
        cs_n = 1'b0;
        wait_cyc(H);
    endtask

    task automatic deselect;
        @(negedge clk);
        cs_n = 1'b1;
        wait_cyc(H);
        chk("R7 so_oe released after deselect", so_oe, 0);
        chk("R3 so quiet while deselected", so, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic seen;
        logic [7:0] si_word;
        wait_cyc(5);
        chk("R9 so_oe in reset", so_oe, 0);
        chk("R9 proto_err in reset", proto_err, 0);
        rst_n = 1'b1;
        wait_cyc(5);
        chk("R3 idle so_oe", so_oe, 0);
        chk("R3 idle so", so, 0);

        // sweep all flag patterns, 16-clock burst each
        for (int p = 0; p < 256; p++) begin
            set_flags(p[7:0]);
            si_word = 8'((p * 7 + 3) & 255);
            select();
            chk("R4 lead so_oe", so_oe, 1);
            chk("R4 lead so low", so, 0);
            chk("R8 clean select no error", proto_err, 0);
            set_flags(~p[7:0]); // R1: must not disturb the snapshot
            for (int k = 0; k < 16; k++) begin
                spi_bit((k < 8) ? si_word[7-k] : 1'b0, seen);
                if (k < 8)
                    chk("R5 R2 R1 snapshot bit", seen, p[7-k]);
                else
                    chk("R6 chained si bit", seen, si_word[15-k]);
            end
            deselect();
        end

        // R7: partial byte then fresh snapshot
        set_flags(8'hC3);
        select();
        for (int k = 0; k < 3; k++) begin
            spi_bit(1'b1, seen);
            chk("R7 partial prefix", seen, 8'hC3 >> (7 - k) & 1);
        end
        deselect();
        set_flags(8'h5A);
        select();
        for (int k = 0; k < 8; k++) begin
            spi_bit(1'b0, seen);
            chk("R7 fresh snapshot after abort", seen, (8'h5A >> (7 - k)) & 1);
        end
        deselect();

        // R8: select while sck high
        set_flags(8'h96);
        @(negedge clk);
        sck = 1'b1;
        wait_cyc(H);
        select();
        chk("R8 proto_err set", proto_err, 1);
        chk("R8 load still driven", so_oe, 1);
        @(negedge clk);
        sck = 1'b0;
        wait_cyc(H);
        for (int k = 0; k < 8; k++) begin
            spi_bit(1'b0, seen);
            chk("R8 snapshot intact after early sck", seen, (8'h96 >> (7 - k)) & 1);
        end
        deselect();
        chk("R8 proto_err holds while idle", proto_err, 1);
        select();
        chk("R8 proto_err cleared by clean select", proto_err, 0);
        deselect();

        // R9: reset in the middle of a transfer
        @(negedge clk);
        sck = 1'b1;
        wait_cyc(H);
        select();
        @(negedge clk);
        sck = 1'b0;
        rst_n = 1'b0;
        wait_cyc(2);
        chk("R9 so_oe dropped by reset", so_oe, 0);
        chk("R9 proto_err cleared by reset", proto_err, 0);
        cs_n = 1'b1;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(H);
        chk("R3 idle after reset", so_oe, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule